// File: doc/BRIEF.md
# Qualified Valley Detection Pulse Generator

This block watches the digital output of a demagnetization comparator on the auxiliary winding of a boost inductor. It marks the point just ahead of a local minimum of the switch's drain-source ringing. A falling edge of the comparator counts as a valley only when the level was high without a break for a programmable number of clock cycles before it fell. A shorter high stretch is treated as a glitch and ignored. Each qualified valley gives a one-cycle pulse and advances a free-running valley counter.

The block also gates switch turn-on for a switching-period controller. That controller pulses an arm strobe and gives a skip count. The block then waits for the (skip+1)-th qualified valley after arming and issues a one-cycle gate-on request, which starts the next switching cycle. Valleys that come while the block is not armed still produce pulses, but they never turn the switch on. Setting the skip count above zero lets turn-on fall on a later valley when the period controller needs a lower frequency.

Top module: `valley_detector`

## Requirements
- R1: While `rst_n` is low, `valley_o`, `valley_cnt_o` and `gate_on_o` are all 0.
- R2: `valley_o` pulses only after a high-to-low transition of the synchronized comparator. Each pulse is exactly one clock cycle wide, and a comparator held at a steady level produces no pulse.
- R3: A falling edge produces a pulse only when `cmp_i` was sampled high on at least `qual_cycles_i` consecutive clock edges before it fell. A threshold of 0 qualifies every falling edge.
- R4: If `cmp_i` is first sampled low at clock edge n, the qualified pulse on `valley_o` is high for the one cycle that follows clock edge n+2.
- R5: A single low sample inside a high stretch ends that stretch. The next high stretch counts from zero, so two short halves do not add up to a qualifying run.
- R6: `valley_cnt_o` increases by exactly one, modulo 2^CNT_W, for every pulse on `valley_o`. This happens whether or not the block is armed.
- R7: After a one-cycle `arm_i` strobe, `gate_on_o` pulses for one cycle. The pulse falls in the cycle after the (`skip_i`+1)-th valley pulse. The block then disarms, and later valleys give no further gate-on until it is armed again.
- R8: While the block is not armed, valley pulses never assert `gate_on_o`.
- R9: With `skip_i` equal to 0, the first valley after arming asserts `gate_on_o`.
- R10: An `arm_i` strobe while the block is already armed restarts the valley count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Demagnetization comparator level (asynchronous) |
| qual_cycles_i | input | 6 | Minimum high time in clock cycles for a falling edge to qualify |
| arm_i | input | 1 | One-cycle strobe from the period controller that arms the gate |
| skip_i | input | 4 | Number of qualified valleys to pass over before turn-on |
| valley_o | output | 1 | One-cycle qualified valley pulse |
| valley_cnt_o | output | 8 | Free-running count of qualified valleys |
| gate_on_o | output | 1 | One-cycle request to start the next switch cycle |

## Verification
High stretches are driven at lengths on both sides of the threshold, including exactly at it and one cycle short. This sets apart a comparison that is `>=` from one that is `>` or that ignores the count. Thresholds of 0, 1 and the 6-bit maximum test the ends of the counter range. High stretches broken by a one-cycle low test whether the count restarts rather than adds up, and a long steady level shows that level alone produces nothing. The gate is exercised with no arm, with skip 0 and skip 2, and with a re-arm in the middle of a count. These cases separate an off-by-one in the skip compare, a missing disarm and a count that survives re-arming.

// File: rtl/vlv_pkg.sv
package vlv_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned QUAL_W      = 6;
  localparam int unsigned SKIP_W      = 4;
  localparam int unsigned CNT_W       = 8;

  typedef enum logic {
    GATE_IDLE  = 1'b0,
    GATE_ARMED = 1'b1
  } gate_st_e;
endpackage

// File: rtl/vlv_sync.sv
module vlv_sync #(
  parameter int unsigned STAGES = vlv_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/vlv_qualify.sv
module vlv_qualify #(
  parameter int unsigned QW = vlv_pkg::QUAL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_i,
  input  logic [QW-1:0] thr_i,
  output logic          valley_o
);
  logic          prev_q;
  logic [QW-1:0] hcnt_q, hcnt_d;
  logic          hcnt_en;
  logic          rise, fall, qualified;
  logic          pulse_d, pulse_q;

  assign rise      = lvl_i & ~prev_q;
  assign fall      = ~lvl_i & prev_q;
  assign qualified = (hcnt_q >= thr_i);

  always_comb begin
    hcnt_en = 1'b0;
    hcnt_d  = hcnt_q;
    if (rise) begin
      hcnt_en = 1'b1;
      hcnt_d  = QW'(1);
    end else if (lvl_i && (hcnt_q < thr_i)) begin
      hcnt_en = 1'b1;
      hcnt_d  = hcnt_q + QW'(1);
    end
    pulse_d = fall & qualified;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      hcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      pulse_q <= pulse_d;
      if (hcnt_en) hcnt_q <= hcnt_d;
    end
  end

  assign valley_o = pulse_q;

  assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  assert_pulse_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (!$past(lvl_i) && $past(prev_q)));

  assert_no_pulse_on_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lvl_i) |-> !pulse_q);
endmodule

// File: rtl/vlv_gate.sv
module vlv_gate #(
  parameter int unsigned SW = vlv_pkg::SKIP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [SW-1:0] skip_i,
  input  logic          valley_i,
  output logic          gate_on_o
);
  import vlv_pkg::*;

  gate_st_e      st_q, st_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          gate_q, gate_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    gate_d = 1'b0;
    if (arm_i) begin
      st_d  = GATE_ARMED;
      cnt_d = '0;
    end else if ((st_q == GATE_ARMED) && valley_i) begin
      if (cnt_q == skip_i) begin
        gate_d = 1'b1;
        st_d   = GATE_IDLE;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GATE_IDLE;
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      gate_q <= gate_d;
    end
  end

  assign gate_on_o = gate_q;

  assert_gate_after_valley_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> $past(valley_i));

  assert_gate_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |=> !gate_q);

  assert_disarm_after_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (st_q == GATE_IDLE));

  assert_idle_no_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == GATE_IDLE) && !arm_i) |=> !gate_q);
endmodule

// File: rtl/valley_detector.sv
module valley_detector #(
  parameter int unsigned QW     = vlv_pkg::QUAL_W,
  parameter int unsigned SW     = vlv_pkg::SKIP_W,
  parameter int unsigned CNT_W  = vlv_pkg::CNT_W,
  parameter int unsigned STAGES = vlv_pkg::SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  input  logic [QW-1:0]    qual_cycles_i,
  input  logic             arm_i,
  input  logic [SW-1:0]    skip_i,
  output logic             valley_o,
  output logic [CNT_W-1:0] valley_cnt_o,
  output logic             gate_on_o
);
  logic             cmp_s;
  logic             valley;
  logic [CNT_W-1:0] vcnt_q, vcnt_d;
  logic             vcnt_en;

  vlv_sync #(.STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  vlv_qualify #(.QW(QW)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_i    (cmp_s),
    .thr_i    (qual_cycles_i),
    .valley_o (valley)
  );

  vlv_gate #(.SW(SW)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .skip_i    (skip_i),
    .valley_i  (valley),
    .gate_on_o (gate_on_o)
  );

  always_comb begin
    vcnt_en = valley;
    vcnt_d  = vcnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vcnt_q <= '0;
    else if (vcnt_en) vcnt_q <= vcnt_d;
  end

  assign valley_o     = valley;
  assign valley_cnt_o = vcnt_q;

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valley_o) |-> (valley_cnt_o == $past(valley_cnt_o) + CNT_W'(1)));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valley_o) |-> $stable(valley_cnt_o));

  assert_reset_outputs_R1: assert property (@(posedge clk)
    !rst_n |-> (!valley_o && !gate_on_o && (valley_cnt_o == '0)));
endmodule

// File: tb/tb_valley_detector.sv
module tb_valley_detector;
  localparam int CLK_PERIOD = 10;
  localparam int QW = 6;
  localparam int SW = 4;
  localparam int CW = 8;
  localparam int WATCHDOG = 100000;
  localparam int NVEC = 10;
  // {high length in cycles, threshold, expected pulses}
  localparam int VEC [NVEC][3] = '{
    '{20, 20, 1}, '{19, 20, 0}, '{1, 20, 0}, '{63, 63, 1}, '{62, 63, 0},
    '{5, 1, 1},   '{1, 1, 1},   '{40, 20, 1}, '{2, 0, 1},  '{21, 20, 1}
  };

  logic          clk;
  logic          rst_n;
  logic          cmp;
  logic [QW-1:0] qual;
  logic          arm;
  logic [SW-1:0] skip;
  logic          valley_o;
  logic [CW-1:0] valley_cnt_o;
  logic          gate_on_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int vpulses = 0;
  int vhigh = 0;
  int gpulses = 0;
  logic v_prev = 1'b0;

  valley_detector dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_i         (cmp),
    .qual_cycles_i (qual),
    .arm_i         (arm),
    .skip_i        (skip),
    .valley_o      (valley_o),
    .valley_cnt_o  (valley_cnt_o),
    .gate_on_o     (gate_on_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valley_o) vhigh++;
      if (valley_o && !v_prev) vpulses++;
      if (gate_on_o) gpulses++;
      v_prev = valley_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int len, input int thr, input int exp);
    int v0, h0;
    @(negedge clk);
    qual = QW'(thr);
    v0 = vpulses;
    h0 = vhigh;
    cmp = 1'b1;
    repeat (len) @(negedge clk);
    cmp = 1'b0;
    repeat (8) @(negedge clk);
    @(posedge clk);
    check("R3 pulses", vpulses - v0, exp);
    check("R2 width", vhigh - h0, exp);
  endtask

  task automatic make_valley();
    @(negedge clk);
    qual = 6'd20;
    cmp = 1'b1;
    repeat (25) @(negedge clk);
    cmp = 1'b0;
    repeat (8) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic do_arm(input int s);
    @(negedge clk);
    arm = 1'b1;
    skip = SW'(s);
    @(negedge clk);
    arm = 1'b0;
  endtask

  initial begin
    int v0, g0, c0, vtot0;
    rst_n = 1'b0;
    cmp = 1'b0;
    qual = 6'd20;
    arm = 1'b0;
    skip = '0;
    repeat (3) @(negedge clk);
    cmp = 1'b1;
    arm = 1'b1;
    @(negedge clk);
    // R1: outputs held at zero in reset
    check("R1 valley", int'(valley_o), 0);
    check("R1 count", int'(valley_cnt_o), 0);
    check("R1 gate", int'(gate_on_o), 0);
    cmp = 1'b0;
    arm = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    c0 = int'(valley_cnt_o);
    vtot0 = vpulses;

    // R2/R3: table of high lengths against thresholds
    for (int i = 0; i < NVEC; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2]);

    // R4: exact latency from the falling edge
    @(negedge clk);
    qual = 6'd4;
    cmp = 1'b1;
    repeat (10) @(negedge clk);
    cmp = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 before", int'(valley_o), 0);
    @(negedge clk);
    check("R4 at", int'(valley_o), 1);
    @(negedge clk);
    check("R4 after", int'(valley_o), 0);
    repeat (4) @(negedge clk);

    // R2: steady high level gives no pulse, its fall gives one
    qual = 6'd20;
    v0 = vpulses;
    cmp = 1'b1;
    repeat (200) @(negedge clk);
    @(posedge clk);
    check("R2 steady high", vpulses - v0, 0);
    @(negedge clk);
    cmp = 1'b0;
    repeat (8) @(negedge clk);
    @(posedge clk);
    check("R2 fall after steady", vpulses - v0, 1);

    // R5: a one-cycle low restarts the count
    @(negedge clk);
    v0 = vpulses;
    cmp = 1'b1;
    repeat (15) @(negedge clk);
    cmp = 1'b0;
    @(negedge clk);
    cmp = 1'b1;
    repeat (15) @(negedge clk);
    cmp = 1'b0;
    repeat (8) @(negedge clk);
    @(posedge clk);
    check("R5 split run", vpulses - v0, 0);
    @(negedge clk);
    v0 = vpulses;
    cmp = 1'b1;
    repeat (30) @(negedge clk);
    cmp = 1'b0;
    @(negedge clk);
    cmp = 1'b1;
    repeat (5) @(negedge clk);
    cmp = 1'b0;
    repeat (8) @(negedge clk);
    @(posedge clk);
    check("R5 long then short", vpulses - v0, 1);

    // R8: unarmed valleys never turn on
    g0 = gpulses;
    repeat (3) make_valley();
    check("R8 unarmed", gpulses - g0, 0);

    // R7: skip 2 fires on the third valley, then disarms
    g0 = gpulses;
    do_arm(2);
    make_valley();
    make_valley();
    check("R7 before third", gpulses - g0, 0);
    make_valley();
    check("R7 third valley", gpulses - g0, 1);
    make_valley();
    check("R7 disarmed", gpulses - g0, 1);

    // R9: skip 0 fires on the first valley
    g0 = gpulses;
    do_arm(0);
    make_valley();
    check("R9 first valley", gpulses - g0, 1);

    // R10: re-arm restarts the count
    g0 = gpulses;
    do_arm(1);
    make_valley();
    do_arm(1);
    make_valley();
    check("R10 after rearm", gpulses - g0, 0);
    make_valley();
    check("R10 second after rearm", gpulses - g0, 1);

    // R6: counter tracks every pulse, armed or not
    @(negedge clk);
    check("R6 counter", (int'(valley_cnt_o) - c0 + 256) % 256, (vpulses - vtot0) % 256);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule